// File: doc/BRIEF.md
# Glitch-free reference clock source switch

This block picks one of two clocks as a reference clock: an internal clock that is always running and an external clock that may stop at any level. A select input chooses the source. It is asynchronous to both clocks and may change at any moment. The output never shows a truncated high or low phase when the source changes. Every high pulse on the output is a complete high phase of one of the two clocks. Between two sources the output rests low for at least half an internal period.

The two directions of the switch use different detection schemes. Going from internal to external, the request is taken in at falling edges of the internal clock, and the internal path closes first. The external path then opens, and only while the external clock is low. Going from external to internal, the request is level-triggered. Once select is high and the external clock is seen low, the internal domain closes the external path by itself. This lets the switch leave an external clock that has stopped low. An external clock stuck high still blocks the return, because closing the path at that moment would cut a high phase.

A prescaler, a divider or power sequencing, if present, sit downstream and are not part of this block.

Top module: `refclk_switch`

## Requirements
- R1: While `rst` is high, `clk_out` is low, because both clock paths are closed.
- R2: After `rst` falls with `sel_int` high (1 = internal, 0 = external), `clk_out` follows `int_clk` within six internal cycles.
- R3: After `sel_int` falls, the internal path closes at a falling edge of `int_clk`. Every low interval of `clk_out` lasts at least half an internal period.
- R4: The external path opens only while `ext_clk` is low. Every high pulse on `clk_out` is the full high phase of `int_clk` or of `ext_clk`. Eight external falling edges after `sel_int` falls, `clk_out` follows `ext_clk`.
- R5: After `sel_int` rises, the external path closes once `ext_clk` is seen low. `clk_out` stays low until a falling edge of `int_clk`, and then follows `int_clk` starting at its next rising edge.
- R6: If `ext_clk` has stopped low, a rise of `sel_int` still brings `clk_out` back to `int_clk`.
- R7: If `ext_clk` has stopped high while it is selected, a rise of `sel_int` leaves `clk_out` high. The switch completes once `ext_clk` toggles again.
- R8: The internal and external paths are never open at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| int_clk | input | 1 | Internal clock, always running; it also clocks the reset |
| ext_clk | input | 1 | External clock, may stop at either level |
| rst | input | 1 | Synchronous active-high reset, sampled at falling edges of `int_clk` |
| sel_int | input | 1 | Asynchronous source select: 1 = internal, 0 = external |
| clk_out | output | 1 | Switched reference clock |

## Verification
Two closing paths for the external clock can fall in the same cycle. One is the external domain's own close at a falling edge of `ext_clk`. The other is the level-triggered close issued from the internal domain. The bench provokes this overlap by sweeping five external half-periods against five select phases relative to `int_clk`, so the two closes race in different orders. Each outcome is judged at the output: every high pulse must match a full phase of one clock, every low gap must be at least half an internal period, and the output must then follow the newly selected clock.

// File: rtl/csw_pkg.sv
`timescale 1ns/1ps
package csw_pkg;

  // default depth of each clock-domain synchronizer
  localparam int unsigned CSW_SYNC_DEFAULT = 2;

  // gate enables handed to the output combiner
  typedef struct packed {
    logic int_on;
    logic ext_on;
  } csw_gate_t;

endpackage

// File: rtl/csw_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer sampling at falling edges (STAGES >= 2).
// ASYNC_CLR selects an asynchronous clear, needed where the local clock may stop.
module csw_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RST_VAL   = 1'b0,
  parameter bit          ASYNC_CLR = 1'b0
) (
  input  logic clk,
  input  logic clr,
  input  logic d,
  output logic q
);

  localparam logic [STAGES-1:0] CLR_VEC = {STAGES{RST_VAL}};

  logic [STAGES-1:0] chain;

  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(negedge clk or posedge clr) begin
        if (clr) chain <= CLR_VEC;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end else begin : g_sync
      always_ff @(negedge clk) begin
        if (clr) chain <= CLR_VEC;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/csw_int_ctrl.sv
`timescale 1ns/1ps
// Internal-clock domain: takes in select, watches the external level,
// owns the internal gate and the level-triggered close of the external path.
module csw_int_ctrl #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic int_clk,
  input  logic rst,
  input  logic sel_int,
  input  logic ext_clk,
  input  logic ext_on,
  output logic int_on,
  output logic ext_clr
);

  logic sel_q;
  logic ext_lo_q;
  logic xen_q;
  logic kill_q;
  logic kill_d;

  csw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1), .ASYNC_CLR(1'b0)) u_sel (
    .clk(int_clk), .clr(rst), .d(sel_int), .q(sel_q)
  );

  csw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .ASYNC_CLR(1'b0)) u_ext_lo (
    .clk(int_clk), .clr(rst), .d(~ext_clk), .q(ext_lo_q)
  );

  // assume the external gate may be open until it is seen closed
  csw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1), .ASYNC_CLR(1'b0)) u_xen (
    .clk(int_clk), .clr(rst), .d(ext_on), .q(xen_q)
  );

  // close request: set while internal is wanted and the external clock is low
  // now and was low in the synchronized history; held until select drops
  assign kill_d = sel_q & (kill_q | (ext_lo_q & ~ext_clk));

  always_ff @(negedge int_clk) begin
    if (rst) begin
      kill_q  <= 1'b1;
      ext_clr <= 1'b1;
      int_on  <= 1'b0;
    end else begin
      kill_q  <= kill_d;
      ext_clr <= kill_d;
      int_on  <= sel_q & kill_q & ~xen_q;
    end
  end

endmodule

// File: rtl/csw_ext_ctrl.sv
`timescale 1ns/1ps
// External-clock domain: opens its gate on a falling edge once the internal
// gate is seen closed; cleared asynchronously by the internal domain.
module csw_ext_ctrl #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic ext_clk,
  input  logic ext_clr,
  input  logic sel_int,
  input  logic int_on,
  output logic ext_on
);

  logic want_q;
  logic ien_q;

  csw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .ASYNC_CLR(1'b1)) u_want (
    .clk(ext_clk), .clr(ext_clr), .d(~sel_int), .q(want_q)
  );

  csw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1), .ASYNC_CLR(1'b1)) u_ien (
    .clk(ext_clk), .clr(ext_clr), .d(int_on), .q(ien_q)
  );

  always_ff @(negedge ext_clk or posedge ext_clr) begin
    if (ext_clr) ext_on <= 1'b0;
    else         ext_on <= want_q & (ext_on | ~ien_q);
  end

endmodule

// File: rtl/csw_gate.sv
`timescale 1ns/1ps
// Output combiner; each enable only changes while its own clock is low.
module csw_gate
  import csw_pkg::*;
(
  input  logic      int_clk,
  input  logic      ext_clk,
  input  csw_gate_t en,
  output logic      clk_out
);

  assign clk_out = (int_clk & en.int_on) | (ext_clk & en.ext_on);

endmodule

// File: rtl/refclk_switch.sv
`timescale 1ns/1ps
module refclk_switch
  import csw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = CSW_SYNC_DEFAULT
) (
  input  logic int_clk,
  input  logic ext_clk,
  input  logic rst,
  input  logic sel_int,
  output logic clk_out
);

  logic      int_on;
  logic      ext_on;
  logic      ext_clr;
  csw_gate_t gate_en;

  csw_int_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_int (
    .int_clk (int_clk),
    .rst     (rst),
    .sel_int (sel_int),
    .ext_clk (ext_clk),
    .ext_on  (ext_on),
    .int_on  (int_on),
    .ext_clr (ext_clr)
  );

  csw_ext_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
    .ext_clk (ext_clk),
    .ext_clr (ext_clr),
    .sel_int (sel_int),
    .int_on  (int_on),
    .ext_on  (ext_on)
  );

  assign gate_en.int_on = int_on;
  assign gate_en.ext_on = ext_on;

  csw_gate u_gate (
    .int_clk (int_clk),
    .ext_clk (ext_clk),
    .en      (gate_en),
    .clk_out (clk_out)
  );

endmodule

// File: rtl/csw_chk.sv
`timescale 1ns/1ps
module csw_chk #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic int_clk,
  input logic rst,
  input logic sel_int,
  input logic int_on,
  input logic ext_on,
  input logic ext_clr
);

  localparam int unsigned LAG   = SYNC_STAGES + 1;
  localparam int unsigned AGE_W = $clog2(LAG + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(LAG);

  logic [AGE_W-1:0] age;

  always_ff @(negedge int_clk) begin
    if (rst)                age <= '0;
    else if (age != AGE_MAX) age <= age + 1'b1;
  end

  AST_NO_OVERLAP: assert property (@(negedge int_clk) disable iff (rst)
    !(int_on && ext_on)); // R8

  AST_CLR_CLOSES_EXT: assert property (@(negedge int_clk) disable iff (rst)
    ext_clr |-> !ext_on); // R5

  AST_INT_OFF_AFTER_SEL: assert property (@(negedge int_clk) disable iff (rst)
    ((age == AGE_MAX) && !$past(sel_int, LAG)) |-> !int_on); // R3

  AST_INT_RISE_NEEDS_SEL: assert property (@(negedge int_clk) disable iff (rst)
    ((age == AGE_MAX) && $rose(int_on)) |-> $past(sel_int, LAG)); // R5

endmodule

bind refclk_switch csw_chk #(.SYNC_STAGES(SYNC_STAGES)) i_csw_chk (
  .int_clk (int_clk),
  .rst     (rst),
  .sel_int (sel_int),
  .int_on  (int_on),
  .ext_on  (ext_on),
  .ext_clr (ext_clr)
);

// File: tb/test_refclk_switch.sv
`timescale 1ns/10ps
module test_refclk_switch;

  localparam realtime INT_HALF = 2.5;   // 200 MHz
  localparam realtime TOL      = 0.05;

  logic int_clk = 1'b0;
  logic ext_clk = 1'b0;
  logic rst     = 1'b1;
  logic sel_int = 1'b1;
  logic clk_out;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  realtime ext_half = 7.0;
  bit      ext_run  = 1'b1;
  bit      ext_lvl  = 1'b0;

  bit      mon_en    = 1'b0;
  bit      mon_armed = 1'b0;
  realtime last_t    = 0.0;

  refclk_switch i_refclk_switch (
    .int_clk (int_clk),
    .ext_clk (ext_clk),
    .rst     (rst),
    .sel_int (sel_int),
    .clk_out (clk_out)
  );

  always #(INT_HALF) int_clk = ~int_clk;

  // external edges stay 0.13 ns off the 0.5 ns grid of internal edges
  initial begin
    #0.13;
    forever begin
      #(ext_half);
      if (ext_run) ext_clk = ~ext_clk;
      else         ext_clk = ext_lvl;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic realtime rabs(input realtime v);
    return (v < 0.0) ? -v : v;
  endfunction

  // pulse-width monitor on the output (widths in units of 10 ps)
  always @(clk_out) begin : mon
    realtime w;
    if (mon_en) begin
      w = $realtime - last_t;
      if (mon_armed) begin
        if (clk_out == 1'b0)
          chk((rabs(w - INT_HALF) < TOL) || (rabs(w - ext_half) < TOL),
              "R4", "high pulse width", int'(w * 100.0), int'(ext_half * 100.0));
        else
          chk(w >= INT_HALF - TOL, "R3", "low gap width",
              int'(w * 100.0), int'(INT_HALF * 100.0));
      end
      mon_armed = 1'b1;
      last_t    = $realtime;
    end
  end

  task automatic follow_int(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(posedge int_clk); #1;
      chk(clk_out == 1'b1, req, "out high in internal high phase", clk_out, 1);
      @(negedge int_clk); #1;
      chk(clk_out == 1'b0, req, "out low in internal low phase", clk_out, 0);
    end
  endtask

  task automatic follow_ext(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(posedge ext_clk); #1;
      chk(clk_out == 1'b1, req, "out high in external high phase", clk_out, 1);
      @(negedge ext_clk); #1;
      chk(clk_out == 1'b0, req, "out low in external low phase", clk_out, 0);
    end
  endtask

  realtime halves [5] = '{3.0, 4.5, 7.0, 11.5, 20.0};

  initial begin
    // R1: reset keeps the output quiet
    repeat (2) @(posedge int_clk);
    for (int i = 0; i < 4; i++) begin
      @(posedge int_clk); #1;
      chk(clk_out == 1'b0, "R1", "out during reset", clk_out, 0);
    end
    @(posedge int_clk); #1.2;
    rst = 1'b0;

    // R2: internal clock after reset
    repeat (6) @(posedge int_clk);
    #1.2;
    mon_armed = 1'b0;
    mon_en    = 1'b1;
    follow_int(8, "R2");

    // sweep of external periods and select phases (R3, R4, R5, R8)
    for (int k = 0; k < 5; k++) begin
      for (int ph = 0; ph < 5; ph++) begin
        ext_half = halves[k];
        repeat (4) @(posedge int_clk);
        #(0.2 + 0.5 * ph);
        sel_int = 1'b0;
        repeat (8) @(negedge ext_clk);
        follow_ext(4, "R4");
        @(posedge int_clk);
        #(0.2 + 0.5 * ((ph + 2) % 5));
        sel_int = 1'b1;
        repeat (40) @(posedge int_clk);
        follow_int(4, "R5");
      end
    end

    // R6: external clock stopped low, return to internal
    ext_half = 7.0;
    repeat (4) @(posedge int_clk);
    #0.7;
    sel_int = 1'b0;
    repeat (8) @(negedge ext_clk);
    follow_ext(3, "R6");
    @(negedge ext_clk);
    ext_lvl = 1'b0;
    ext_run = 1'b0;
    repeat (3) @(posedge int_clk);
    #0.2;
    sel_int = 1'b1;
    repeat (20) @(posedge int_clk);
    follow_int(6, "R6");
    ext_run = 1'b1;
    repeat (10) @(posedge int_clk);

    // R7: external clock stopped high blocks the return
    @(posedge int_clk); #1.2;
    sel_int = 1'b0;
    repeat (8) @(negedge ext_clk);
    follow_ext(3, "R7");
    @(posedge ext_clk);
    mon_en  = 1'b0;
    ext_lvl = 1'b1;
    ext_run = 1'b0;
    repeat (2) @(posedge int_clk);
    #0.2;
    sel_int = 1'b1;
    repeat (30) @(posedge int_clk);
    for (int i = 0; i < 4; i++) begin
      @(posedge int_clk); #1;
      chk(clk_out == 1'b1, "R7", "out held by stuck-high external", clk_out, 1);
      @(negedge int_clk); #1;
      chk(clk_out == 1'b1, "R7", "out held by stuck-high external", clk_out, 1);
    end
    ext_run = 1'b1;
    repeat (40) @(posedge int_clk);
    #1.2;
    mon_armed = 1'b0;
    mon_en    = 1'b1;
    follow_int(6, "R7");
    repeat (4) @(posedge int_clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge int_clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule